// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block keeps a small circular queue of in-flight stores and answers byte-level forwarding queries from a two-stage load pipeline. A store is allocated at the tail of the queue. Its address part and its data part can then be written into that entry independently and in either order. The address part is a virtual address, a physical address and a 2-bit size code. The data part is a size code and up to 64 bits of data. Stores leave the queue from the head.

A load presents its virtual address, physical address, byte mask and a one-bit-per-entry vector that marks the store entries older than the load. In the same cycle (load stage 1) the unit returns a fast byte-valid mask and a fast data-not-ready flag. One cycle later (stage 2) it returns the registered byte-valid mask together with the forwarded bytes, the data-not-ready flag, the index of the entry that blocks forwarding, and a flag that requests a flush when the virtual and physical address searches disagree.

Top module: `stl_forward_queue`

## Requirements
- R1: A store's byte mask is the size code's base pattern (code 0 gives 0x01, code 1 gives 0x03, code 2 gives 0x0F, code 3 gives 0xFF) shifted left by virtual address bits [2:0] and truncated to 8 bits. Bit b of the mask stands for byte b, which is data bits [8b+7:8b].
- R2: Store data is held as its low 1, 2, 4 or 8 bytes (size codes 0 to 3) repeated across all 8 byte lanes.
- R3: For each byte that is set in the load mask, the unit forwards from the youngest store among the entries marked older whose doubleword virtual address (bits above bit 2) equals the load's and whose mask covers that byte. A byte that is not covered, or is not in the load mask, reports valid 0 and data 0.
- R4: Entries whose bit in the older-entries vector is 0 never take part in forwarding. Age is counted from the queue head, so after wrap-around a lower index can be the younger entry.
- R5: An entry whose address part has not been written never matches.
- R6: If the selected store for some requested byte has no data yet, that byte reports valid 0 and the stage-1 data-not-ready flag is raised. In stage 2 the flag is repeated, and the index output gives the youngest such blocking entry.
- R7: In stage 2 a match-invalid flag is 1 when the set of entries hit by the virtual-address search differs from the set hit by the physical-address search. Both searches use the same older, address-valid and byte-overlap conditions.
- R8: Every stage-2 output is the stage-1 result of the previous cycle, registered.
- R9: When the load query valid is low, the stage-1 mask and flag are zero, and so are all stage-2 outputs in the next cycle.
- R10: An allocation takes the entry at the tail and advances the tail. A retire frees the head entry and advances the head. An allocation while 8 entries are in use is ignored, and the full output is 1 exactly when all entries are in use.
- R11: After reset the queue is empty, the allocation index is 0, full is 0 and all load responses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_en | input | 1 | Allocate a store entry at the tail |
| alloc_idx | output | 3 | Index of the next entry to be allocated |
| q_full | output | 1 | All entries are in use |
| retire_en | input | 1 | Free the head entry |
| sa_en | input | 1 | Write the address part of a store |
| sa_idx | input | 3 | Entry receiving the address part |
| sa_va | input | 16 | Store virtual address |
| sa_pa | input | 20 | Store physical address |
| sa_size | input | 2 | Store size code for the mask |
| sd_en | input | 1 | Write the data part of a store |
| sd_idx | input | 3 | Entry receiving the data part |
| sd_size | input | 2 | Store size code for replication |
| sd_data | input | 64 | Store data, low bytes significant |
| ld_valid | input | 1 | Load query valid in stage 1 |
| ld_va | input | 16 | Load virtual address |
| ld_pa | input | 20 | Load physical address |
| ld_mask | input | 8 | Load byte mask |
| ld_older | input | 8 | One bit per entry, 1 when that store is older than the load |
| s1_fwd_mask | output | 8 | Stage-1 fast byte-valid mask |
| s1_nrdy | output | 1 | Stage-1 fast data-not-ready flag |
| s2_fwd_mask | output | 8 | Stage-2 byte-valid mask |
| s2_fwd_data | output | 64 | Stage-2 forwarded bytes |
| s2_nrdy | output | 1 | Stage-2 data-not-ready flag |
| s2_nrdy_idx | output | 3 | Youngest entry blocking forwarding |
| s2_match_bad | output | 1 | Virtual and physical search results disagree |

## Verification
Queries are aimed at one doubleword that is covered by overlapping stores of several sizes, so a word store, a later byte store and a full doubleword store compete for the same lanes. Changing the older-entries vector, the load mask and the address separates age selection, lane masking and address matching from each other. A store with its address written but no data tells data-not-ready apart from a plain miss, and an allocated entry with no address checks that unaddressed entries are ignored. A physical address mismatch on an otherwise hitting load triggers the flush flag. After a retire and a wrap-around refill, index 0 becomes the youngest entry, which tests that age is counted from the head and not from the raw index.

// File: rtl/stl_forward_queue.sv
module stl_forward_queue #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 16,
  parameter int PA_W    = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_en,
  output logic [$clog2(ENTRIES)-1:0] alloc_idx,
  output logic                       q_full,
  input  logic                       retire_en,
  input  logic                       sa_en,
  input  logic [$clog2(ENTRIES)-1:0] sa_idx,
  input  logic [VA_W-1:0]            sa_va,
  input  logic [PA_W-1:0]            sa_pa,
  input  logic [1:0]                 sa_size,
  input  logic                       sd_en,
  input  logic [$clog2(ENTRIES)-1:0] sd_idx,
  input  logic [1:0]                 sd_size,
  input  logic [63:0]                sd_data,
  input  logic                       ld_valid,
  input  logic [VA_W-1:0]            ld_va,
  input  logic [PA_W-1:0]            ld_pa,
  input  logic [7:0]                 ld_mask,
  input  logic [ENTRIES-1:0]         ld_older,
  output logic [7:0]                 s1_fwd_mask,
  output logic                       s1_nrdy,
  output logic [7:0]                 s2_fwd_mask,
  output logic [63:0]                s2_fwd_data,
  output logic                       s2_nrdy,
  output logic [$clog2(ENTRIES)-1:0] s2_nrdy_idx,
  output logic                       s2_match_bad
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = IDX_W + 1;

  function automatic logic [7:0] size_to_mask(input logic [1:0] sz, input logic [2:0] off);
    logic [7:0] base;
    case (sz)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << off;
  endfunction

  function automatic logic [63:0] replicate(input logic [1:0] sz, input logic [63:0] d);
    case (sz)
      2'd0:    return {8{d[7:0]}};
      2'd1:    return {4{d[15:0]}};
      2'd2:    return {2{d[31:0]}};
      default: return d;
    endcase
  endfunction

  logic [ENTRIES-1:0] ent_v, addr_v, data_v;
  logic [VA_W-1:0]    ent_va   [ENTRIES];
  logic [PA_W-1:0]    ent_pa   [ENTRIES];
  logic [7:0]         ent_mask [ENTRIES];
  logic [63:0]        ent_data [ENTRIES];
  logic [IDX_W-1:0]   head, tail;
  logic [CNT_W-1:0]   count;

  wire alloc_ok  = alloc_en && !q_full;
  wire retire_ok = retire_en && (count != '0);

  assign q_full    = (count == CNT_W'(ENTRIES));
  assign alloc_idx = tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v  <= '0;
      addr_v <= '0;
      data_v <= '0;
      head   <= '0;
      tail   <= '0;
      count  <= '0;
    end else begin
      if (sa_en && ent_v[sa_idx]) addr_v[sa_idx] <= 1'b1;
      if (sd_en && ent_v[sd_idx]) data_v[sd_idx] <= 1'b1;
      if (alloc_ok) begin
        ent_v[tail]  <= 1'b1;
        addr_v[tail] <= 1'b0;
        data_v[tail] <= 1'b0;
        tail         <= tail + 1'b1;
      end
      if (retire_ok) begin
        ent_v[head]  <= 1'b0;
        addr_v[head] <= 1'b0;
        data_v[head] <= 1'b0;
        head         <= head + 1'b1;
      end
      count <= count + CNT_W'(alloc_ok) - CNT_W'(retire_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (sa_en) begin
      ent_va[sa_idx]   <= sa_va;
      ent_pa[sa_idx]   <= sa_pa;
      ent_mask[sa_idx] <= size_to_mask(sa_size, sa_va[2:0]);
    end
    if (sd_en) ent_data[sd_idx] <= replicate(sd_size, sd_data);
  end

  logic [ENTRIES-1:0] va_hit, pa_hit, blocked;
  logic [7:0]         sel_v;
  logic [IDX_W-1:0]   sel_e [8];
  logic [63:0]        s1_data;
  logic [IDX_W-1:0]   s1_nrdy_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      va_hit[i] = ld_valid && ent_v[i] && addr_v[i] && ld_older[i] &&
                  (ent_va[i][VA_W-1:3] == ld_va[VA_W-1:3]) && |(ent_mask[i] & ld_mask);
      pa_hit[i] = ld_valid && ent_v[i] && addr_v[i] && ld_older[i] &&
                  (ent_pa[i][PA_W-1:3] == ld_pa[PA_W-1:3]) && |(ent_mask[i] & ld_mask);
    end
  end

  always_comb begin
    sel_v = '0;
    for (int b = 0; b < 8; b++) sel_e[b] = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      logic [IDX_W-1:0] e;
      e = head + IDX_W'(k);
      for (int b = 0; b < 8; b++) begin
        if (va_hit[e] && ent_mask[e][b] && ld_mask[b]) begin
          sel_v[b] = 1'b1;
          sel_e[b] = e;
        end
      end
    end
  end

  always_comb begin
    blocked     = '0;
    s1_fwd_mask = '0;
    s1_data     = '0;
    for (int b = 0; b < 8; b++) begin
      if (sel_v[b]) begin
        if (data_v[sel_e[b]]) begin
          s1_fwd_mask[b]     = 1'b1;
          s1_data[8*b +: 8]  = ent_data[sel_e[b]][8*b +: 8];
        end else begin
          blocked[sel_e[b]]  = 1'b1;
        end
      end
    end
    s1_nrdy_idx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      logic [IDX_W-1:0] e;
      e = head + IDX_W'(k);
      if (blocked[e]) s1_nrdy_idx = e;
    end
  end

  assign s1_nrdy = |blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_fwd_mask  <= '0;
      s2_fwd_data  <= '0;
      s2_nrdy      <= 1'b0;
      s2_nrdy_idx  <= '0;
      s2_match_bad <= 1'b0;
    end else begin
      s2_fwd_mask  <= s1_fwd_mask;
      s2_fwd_data  <= s1_data;
      s2_nrdy      <= s1_nrdy;
      s2_nrdy_idx  <= s1_nrdy_idx;
      s2_match_bad <= ld_valid && (va_hit != pa_hit);
    end
  end

  AST_S2_FOLLOWS_S1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (s2_fwd_mask == $past(s1_fwd_mask) && s2_nrdy == $past(s1_nrdy))); // R8
  AST_FWD_INSIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_fwd_mask & ~ld_mask) == 8'h00); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (s1_fwd_mask == 8'h00 && !s1_nrdy)); // R9
  AST_OCCUPANCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ENTRIES)); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && alloc_en && !retire_en) |=> (q_full && $stable(tail))); // R10
  AST_NRDY_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    s1_nrdy |-> (s1_fwd_mask != ld_mask || ld_mask == 8'h00) ); // R6
endmodule

// File: tb/test_stl_forward_queue.sv
module test_stl_forward_queue;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_en = 0, retire_en = 0, sa_en = 0, sd_en = 0, ld_valid = 0;
  logic [2:0]  alloc_idx, sa_idx = 0, sd_idx = 0, s2_nrdy_idx;
  logic        q_full, s1_nrdy, s2_nrdy, s2_match_bad;
  logic [15:0] sa_va = 0, ld_va = 0;
  logic [19:0] sa_pa = 0, ld_pa = 0;
  logic [1:0]  sa_size = 0, sd_size = 0;
  logic [63:0] sd_data = 0, s2_fwd_data;
  logic [7:0]  ld_mask = 0, ld_older = 0, s1_fwd_mask, s2_fwd_mask;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stl_forward_queue i_stl_forward_queue (
    .clk, .rst_n, .alloc_en, .alloc_idx, .q_full, .retire_en,
    .sa_en, .sa_idx, .sa_va, .sa_pa, .sa_size,
    .sd_en, .sd_idx, .sd_size, .sd_data,
    .ld_valid, .ld_va, .ld_pa, .ld_mask, .ld_older,
    .s1_fwd_mask, .s1_nrdy, .s2_fwd_mask, .s2_fwd_data,
    .s2_nrdy, .s2_nrdy_idx, .s2_match_bad
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_alloc();
    @(negedge clk); alloc_en = 1;
    @(negedge clk); alloc_en = 0;
  endtask

  task automatic do_retire();
    @(negedge clk); retire_en = 1;
    @(negedge clk); retire_en = 0;
  endtask

  task automatic write_addr(input logic [2:0] idx, input logic [15:0] va,
                            input logic [19:0] pa, input logic [1:0] sz);
    @(negedge clk); sa_en = 1; sa_idx = idx; sa_va = va; sa_pa = pa; sa_size = sz;
    @(negedge clk); sa_en = 0;
  endtask

  task automatic write_data(input logic [2:0] idx, input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk); sd_en = 1; sd_idx = idx; sd_size = sz; sd_data = d;
    @(negedge clk); sd_en = 0;
  endtask

  task automatic query(input string tag, input logic [15:0] va, input logic [19:0] pa,
                       input logic [7:0] m, input logic [7:0] older,
                       input logic [7:0] e_mask, input logic e_nrdy, input logic [63:0] e_data,
                       input logic [2:0] e_idx, input logic e_bad);
    @(negedge clk);
    ld_valid = 1; ld_va = va; ld_pa = pa; ld_mask = m; ld_older = older;
    #1;
    chk({tag, " s1 mask"}, 64'(s1_fwd_mask), 64'(e_mask));
    chk({tag, " s1 nrdy"}, 64'(s1_nrdy), 64'(e_nrdy));
    @(posedge clk); #1;
    chk({tag, " s2 mask (R8)"}, 64'(s2_fwd_mask), 64'(e_mask));
    chk({tag, " s2 data"}, s2_fwd_data, e_data);
    chk({tag, " s2 nrdy (R8)"}, 64'(s2_nrdy), 64'(e_nrdy));
    if (e_nrdy) chk({tag, " s2 nrdy idx R6"}, 64'(s2_nrdy_idx), 64'(e_idx));
    chk({tag, " s2 match_bad R7"}, 64'(s2_match_bad), 64'(e_bad));
    ld_valid = 0;
  endtask

  task automatic t_reset();
    chk("R11 alloc_idx", 64'(alloc_idx), 0);
    chk("R11 full", 64'(q_full), 0);
    chk("R11 s1 mask", 64'(s1_fwd_mask), 0);
    chk("R11 s2 mask", 64'(s2_fwd_mask), 0);
    chk("R11 s2 bad", 64'(s2_match_bad), 0);
  endtask

  task automatic t_word_store();
    do_alloc();
    write_addr(3'd0, 16'h0104, 20'h10104, 2'd2);
    write_data(3'd0, 2'd2, 64'h0000_0000_1122_3344);
    query("R1 R2 word", 16'h0100, 20'h10100, 8'hFF, 8'h01,
          8'hF0, 0, 64'h1122_3344_0000_0000, 0, 0);
  endtask

  task automatic t_youngest();
    do_alloc();
    write_addr(3'd1, 16'h0105, 20'h10105, 2'd0);
    write_data(3'd1, 2'd0, 64'h0000_0000_0000_00AB);
    query("R3 youngest byte", 16'h0100, 20'h10100, 8'hFF, 8'h03,
          8'hF0, 0, 64'h1122_AB44_0000_0000, 0, 0);
    query("R4 not older", 16'h0100, 20'h10100, 8'hFF, 8'h01,
          8'hF0, 0, 64'h1122_3344_0000_0000, 0, 0);
    query("R3 load mask", 16'h0100, 20'h10100, 8'h0F, 8'h03,
          8'h00, 0, 64'h0, 0, 0);
    query("R3 other dword", 16'h0108, 20'h10108, 8'hFF, 8'h03,
          8'h00, 0, 64'h0, 0, 0);
  endtask

  task automatic t_not_ready();
    do_alloc();
    write_addr(3'd2, 16'h0100, 20'h10100, 2'd3);
    query("R6 no data", 16'h0100, 20'h10100, 8'hFF, 8'h07,
          8'h00, 1, 64'h0, 3'd2, 0);
    query("R6 older only", 16'h0100, 20'h10100, 8'hFF, 8'h03,
          8'hF0, 0, 64'h1122_AB44_0000_0000, 0, 0);
  endtask

  task automatic t_no_addr();
    do_alloc();
    query("R5 unaddressed", 16'h0100, 20'h10100, 8'hFF, 8'h0F,
          8'h00, 1, 64'h0, 3'd2, 0);
  endtask

  task automatic t_mismatch();
    do_alloc();
    write_addr(3'd4, 16'h0200, 20'h20200, 2'd3);
    write_data(3'd4, 2'd3, 64'h0102_0304_0506_0708);
    query("R7 pa differs", 16'h0200, 20'h30200, 8'hFF, 8'h10,
          8'hFF, 0, 64'h0102_0304_0506_0708, 0, 1);
    query("R7 pa agrees", 16'h0200, 20'h20200, 8'hFF, 8'h10,
          8'hFF, 0, 64'h0102_0304_0506_0708, 0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    ld_valid = 0; ld_va = 16'h0200; ld_pa = 20'h30200; ld_mask = 8'hFF; ld_older = 8'hFF;
    #1;
    chk("R9 s1 mask idle", 64'(s1_fwd_mask), 0);
    chk("R9 s1 nrdy idle", 64'(s1_nrdy), 0);
    @(posedge clk); #1;
    chk("R9 s2 mask idle", 64'(s2_fwd_mask), 0);
    chk("R9 s2 bad idle", 64'(s2_match_bad), 0);
    chk("R9 s2 nrdy idle", 64'(s2_nrdy), 0);
  endtask

  task automatic t_queue();
    chk("R10 tail after 5", 64'(alloc_idx), 5);
    do_retire();
    query("R10 retired head", 16'h0100, 20'h10100, 8'hFF, 8'h03,
          8'h20, 0, 64'h0000_AB00_0000_0000, 0, 0);
    for (int n = 0; n < 4; n++) do_alloc();
    chk("R10 full", 64'(q_full), 1);
    chk("R10 tail wrapped", 64'(alloc_idx), 1);
    do_alloc();
    chk("R10 alloc when full ignored", 64'(alloc_idx), 1);
    write_addr(3'd0, 16'h0100, 20'h10100, 2'd3);
    write_data(3'd0, 2'd0, 64'h0000_0000_0000_00CC);
    query("R4 wrap age", 16'h0100, 20'h10100, 8'hFF, 8'h03,
          8'hFF, 0, 64'hCCCC_CCCC_CCCC_CCCC, 0, 0);
    for (int n = 0; n < 8; n++) do_retire();
    chk("R10 drained", 64'(q_full), 0);
    query("R10 drained no hit", 16'h0100, 20'h10100, 8'hFF, 8'hFF,
          8'h00, 0, 64'h0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_word_store();
    t_youngest();
    t_not_ready();
    t_no_addr();
    t_mismatch();
    t_idle();
    t_queue();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule